// File: doc/BRIEF.md
# Dual-Source Wake-Up Detector

This block watches for wake requests while a bus node is parked in a low-power state (sleep or silent). Two sources are filtered. The first is a remote wake on the synchronized bus receive level, which is low when dominant and high when recessive. The second is a local wake on a switch input that is active low. All timing is counted in units of an external one-microsecond tick strobe. The filter lengths are parameters, so a bench can shorten them.

Each source produces a one-cycle wake event when its request qualifies. The first qualifying source is also latched into a source flag that the mode controller reads. The flags clear as soon as the controller is back in normal mode with the enable input high. The block has no data stream, so every pin is a plain level or strobe and no back-pressure applies.

Top module: `wake_detector`

## Requirements
- R1: In sleep or silent mode, a bus wake needs three steps in order: a falling edge of `bus_lvl`, a low level held for `BUS_FILT_TICKS` tick strobes, and then a rising edge. `bus_wake` pulses in the cycle after the clock edge that first samples `bus_lvl` high again.
- R2: If `bus_lvl` returns high before `BUS_FILT_TICKS` ticks have been counted, the attempt is dropped with no event. The next falling edge starts a fresh count.
- R3: A low bus level that is already present when detection becomes active does not count. `bus_lvl` must first be seen high before a falling edge can start a request.
- R4: In silent mode (`mode` = 2'b01) a bus wake is accepted only while `txd` is high. A low `txd` aborts any bus request in progress.
- R5: A local wake fires while `wk_pin` is still low. The pin must have a falling edge and then be held low for `LOC_FILT_TICKS` ticks. `loc_wake` pulses in the cycle after the edge that samples the last of those ticks, and no rising edge is needed. A shorter low level gives no event.
- R6: Before a local request can start, `wk_pin` must be high for `REARM_TICKS` consecutive ticks. This applies after a local wake and also when detection first becomes active. A shorter high period does not re-arm.
- R7: Detection runs only in sleep (`mode` = 2'b10) and silent (`mode` = 2'b01). In normal (2'b00) and fail-safe (2'b11) modes no event fires and both filters restart.
- R8: The source flags `src_bus` and `src_loc` are set in the cycle after an event. They are never both high. The first source latched is kept until it is cleared, and a later event does not overwrite it. When both events occur in the same cycle, `src_bus` is the one set.
- R9: When `en` is high and `mode` is normal (2'b00) at a clock edge, both flags read low from the next cycle on.
- R10: Each of `bus_wake` and `loc_wake` is high for exactly one cycle per qualified request.
- R11: After reset both events and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per microsecond |
| mode | input | 2 | 00 normal, 01 silent, 10 sleep, 11 fail-safe |
| en | input | 1 | Enable level from the host controller |
| txd | input | 1 | Transmit input level |
| bus_lvl | input | 1 | Synchronized bus level, 0 = dominant |
| wk_pin | input | 1 | Synchronized local wake input, 0 = active |
| bus_wake | output | 1 | One-cycle remote wake event |
| loc_wake | output | 1 | One-cycle local wake event |
| src_bus | output | 1 | Latched flag: remote wake was the source |
| src_loc | output | 1 | Latched flag: local wake was the source |

## Verification
The bus input is driven with several patterns. A long dominant pulse in each mode checks that the mode gate works. A short pulse followed by a long one shows that an aborted count does not carry over. A line that is already low when sleep is entered shows that a true falling edge is required. In silent mode the same pulse is sent with `txd` low and then high, to isolate the transmit gate. The local pin is driven with a long low level, which must fire before release, and then with a brief high period followed by a longer one, which separates failed re-arming from correct re-arming. Finally, both sources are made to qualify in the same cycle, and a second source arrives while a flag is already set, which exercises tie priority and first-source retention.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_SILENT   = 2'b01,
    MODE_SLEEP    = 2'b10,
    MODE_FAILSAFE = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    BW_NEED_HIGH,
    BW_ARMED,
    BW_DOMINANT,
    BW_QUALIFIED
  } bus_st_e;

  typedef enum logic [1:0] {
    LW_REARM,
    LW_ARMED,
    LW_LOW
  } loc_st_e;
endpackage

// File: rtl/wk_tick_cnt.sv
module wk_tick_cnt #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] TOP  = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign done = inc && !clr && (cnt == LAST);

  // R1 R5 R6: counter stays inside its window
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
endmodule

// File: rtl/wk_bus_filter.sv
module wk_bus_filter
  import wk_pkg::*;
#(
  parameter int FILT_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic bus_lvl,
  output logic wake
);
  bus_st_e st, st_nx;
  logic    done;

  wk_tick_cnt #(.LIMIT(FILT_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st != BW_DOMINANT), .inc(tick), .done(done)
  );

  always_comb begin
    st_nx = st;
    if (!active) st_nx = BW_NEED_HIGH;
    else begin
      unique case (st)
        BW_NEED_HIGH: if (bus_lvl) st_nx = BW_ARMED;
        BW_ARMED:     if (!bus_lvl) st_nx = BW_DOMINANT;
        BW_DOMINANT:  if (bus_lvl) st_nx = BW_ARMED;
                      else if (done) st_nx = BW_QUALIFIED;
        BW_QUALIFIED: if (bus_lvl) st_nx = BW_ARMED;
        default:      st_nx = BW_NEED_HIGH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= BW_NEED_HIGH;
      wake <= 1'b0;
    end else begin
      st   <= st_nx;
      wake <= active && (st == BW_QUALIFIED) && bus_lvl;
    end
  end

  // R1: an event follows a recessive sample
  bus_evt_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(bus_lvl));
  // R10: single-cycle event
  bus_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
endmodule

// File: rtl/wk_loc_filter.sv
module wk_loc_filter
  import wk_pkg::*;
#(
  parameter int FILT_TICKS  = 100,
  parameter int REARM_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic pin,
  output logic wake
);
  loc_st_e st, st_nx;
  logic    hi_done, lo_done;

  wk_tick_cnt #(.LIMIT(REARM_TICKS)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(!active || st != LW_REARM || !pin),
    .inc(tick), .done(hi_done)
  );
  wk_tick_cnt #(.LIMIT(FILT_TICKS)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(st != LW_LOW),
    .inc(tick), .done(lo_done)
  );

  always_comb begin
    st_nx = st;
    if (!active) st_nx = LW_REARM;
    else begin
      unique case (st)
        LW_REARM: if (hi_done) st_nx = LW_ARMED;
        LW_ARMED: if (!pin) st_nx = LW_LOW;
        LW_LOW:   if (pin) st_nx = LW_ARMED;
                  else if (lo_done) st_nx = LW_REARM;
        default:  st_nx = LW_REARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= LW_REARM;
      wake <= 1'b0;
    end else begin
      st   <= st_nx;
      wake <= active && (st == LW_LOW) && !pin && lo_done;
    end
  end

  // R5: event only while the pin was low and detection active
  loc_evt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(active) && !$past(pin)));
  // R10: single-cycle event
  loc_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
endmodule

// File: rtl/wk_src_latch.sv
module wk_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_evt,
  input  logic loc_evt,
  input  logic clear,
  output logic src_bus,
  output logic src_loc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_bus <= 1'b0;
      src_loc <= 1'b0;
    end else if (clear) begin
      src_bus <= 1'b0;
      src_loc <= 1'b0;
    end else if (!src_bus && !src_loc) begin
      src_bus <= bus_evt;
      src_loc <= loc_evt && !bus_evt;
    end
  end

  // R8: at most one source flag
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_bus, src_loc}));
  // R8: a latched source is retained until cleared
  src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_bus || src_loc) && !clear) |=> $stable({src_bus, src_loc}));
  // R9: clear empties the flags
  src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!src_bus && !src_loc));
endmodule

// File: rtl/wake_detector.sv
module wake_detector
  import wk_pkg::*;
#(
  parameter int BUS_FILT_TICKS = 100,
  parameter int LOC_FILT_TICKS = 100,
  parameter int REARM_TICKS    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       en,
  input  logic       txd,
  input  logic       bus_lvl,
  input  logic       wk_pin,
  output logic       bus_wake,
  output logic       loc_wake,
  output logic       src_bus,
  output logic       src_loc
);
  logic det_on, bus_on, clr_src;

  assign det_on  = (mode == MODE_SILENT) || (mode == MODE_SLEEP);
  assign bus_on  = det_on && !((mode == MODE_SILENT) && !txd);
  assign clr_src = en && (mode == MODE_NORMAL);

  wk_bus_filter #(.FILT_TICKS(BUS_FILT_TICKS)) u_bus (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(bus_on),
    .bus_lvl(bus_lvl), .wake(bus_wake)
  );

  wk_loc_filter #(.FILT_TICKS(LOC_FILT_TICKS), .REARM_TICKS(REARM_TICKS)) u_loc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(det_on),
    .pin(wk_pin), .wake(loc_wake)
  );

  wk_src_latch u_src (
    .clk(clk), .rst_n(rst_n), .bus_evt(bus_wake), .loc_evt(loc_wake),
    .clear(clr_src), .src_bus(src_bus), .src_loc(src_loc)
  );

  // R4: silent-mode bus wake needs txd high
  silent_txd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wake && $past(mode) == MODE_SILENT) |-> $past(txd));
  // R7: no events outside the low-power modes
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_NORMAL || $past(mode) == MODE_FAILSAFE)
      |-> (!bus_wake && !loc_wake));
endmodule

// File: tb/tb_wake_detector.sv
module tb_wake_detector;
  localparam int BUS_F = 8;
  localparam int LOC_F = 6;
  localparam int RE_F  = 3;
  localparam int TP    = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] mode = 2'b00;
  logic en = 1'b0, txd = 1'b1, bus_lvl = 1'b1, wk_pin = 1'b1;
  logic bus_wake, loc_wake, src_bus, src_loc;

  int checks = 0, fails = 0, tc = 0;
  int n_bus = 0, n_loc = 0, run_b = 0, run_l = 0, max_run = 0;
  bit finished = 0;

  // reference model state
  bit m_bw, m_lw, m_sb, m_sl;
  bit b_seen_hi, b_in_low, b_ok;
  int b_ticks;
  bit l_armed, l_in_low;
  int l_hi, l_lo;

  always #2 clk = ~clk;

  wake_detector #(.BUS_FILT_TICKS(BUS_F), .LOC_FILT_TICKS(LOC_F),
                  .REARM_TICKS(RE_F)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .en(en), .txd(txd),
    .bus_lvl(bus_lvl), .wk_pin(wk_pin), .bus_wake(bus_wake),
    .loc_wake(loc_wake), .src_bus(src_bus), .src_loc(src_loc)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bw = 0; m_lw = 0; m_sb = 0; m_sl = 0;
      b_seen_hi = 0; b_in_low = 0; b_ok = 0; b_ticks = 0;
      l_armed = 0; l_in_low = 0; l_hi = 0; l_lo = 0;
    end else begin
      bit detect, bus_gate, nbw, nlw;
      detect   = (mode == 2'b01) || (mode == 2'b10);
      bus_gate = detect && !(mode == 2'b01 && !txd);
      nbw = 0; nlw = 0;
      if (en && mode == 2'b00) begin m_sb = 0; m_sl = 0; end
      else if (!m_sb && !m_sl) begin
        if (m_bw) m_sb = 1; else if (m_lw) m_sl = 1;
      end
      if (!bus_gate) begin b_seen_hi = 0; b_in_low = 0; b_ok = 0; b_ticks = 0; end
      else if (b_ok) begin
        if (bus_lvl) begin nbw = 1; b_ok = 0; b_in_low = 0; b_seen_hi = 1; end
      end else if (b_in_low) begin
        if (bus_lvl) b_in_low = 0;
        else if (tick) begin b_ticks++; if (b_ticks == BUS_F) b_ok = 1; end
      end else if (!b_seen_hi) begin
        if (bus_lvl) b_seen_hi = 1;
      end else if (!bus_lvl) begin b_in_low = 1; b_ticks = 0; end
      if (!detect) begin l_armed = 0; l_in_low = 0; l_hi = 0; l_lo = 0; end
      else if (l_in_low) begin
        if (wk_pin) l_in_low = 0;
        else if (tick) begin
          l_lo++;
          if (l_lo == LOC_F) begin nlw = 1; l_in_low = 0; l_armed = 0; l_hi = 0; end
        end
      end else if (l_armed) begin
        if (!wk_pin) begin l_in_low = 1; l_lo = 0; end
      end else begin
        if (!wk_pin) l_hi = 0;
        else if (tick) begin l_hi++; if (l_hi == RE_F) l_armed = 1; end
      end
      m_bw = nbw; m_lw = nlw;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check("R1 bus_wake vs model", bus_wake, m_bw);
    check("R5 loc_wake vs model", loc_wake, m_lw);
    check("R8 src_bus vs model", src_bus, m_sb);
    check("R8 src_loc vs model", src_loc, m_sl);
    if (bus_wake) n_bus++;
    if (loc_wake) n_loc++;
    run_b = bus_wake ? run_b + 1 : 0;
    run_l = loc_wake ? run_l + 1 : 0;
    if (run_b > max_run) max_run = run_b;
    if (run_l > max_run) max_run = run_l;
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (tc == TP - 1);
      tc = (tc + 1) % TP;
    end
  endtask

  task automatic zero();
    n_bus = 0; n_loc = 0;
  endtask

  task automatic bus_pulse(int ticks);
    bus_lvl = 0; step(ticks * TP); bus_lvl = 1; step(3 * TP);
  endtask

  task automatic clear_flags(logic [1:0] back);
    mode = 2'b00; en = 1; step(2); en = 0; mode = back; step((RE_F + 2) * TP);
  endtask

  initial begin
    step(3);
    check("R11 reset bus_wake", bus_wake, 0);
    check("R11 reset src flags", {src_bus, src_loc}, 0);
    rst_n = 1; step(2);
    check("R11 after reset", {bus_wake, loc_wake, src_bus, src_loc}, 0);

    // R7 normal and fail-safe ignore both sources
    zero(); step(4); bus_pulse(BUS_F + 4);
    wk_pin = 0; step((LOC_F + 3) * TP); wk_pin = 1; step(2);
    mode = 2'b11; bus_pulse(BUS_F + 4);
    check("R7 no event outside low-power", n_bus + n_loc, 0);

    // R1 full bus sequence in sleep
    mode = 2'b10; step(4); zero(); bus_pulse(BUS_F + 2);
    check("R1 bus wake count", n_bus, 1);
    check("R8 src_bus set", src_bus, 1);
    clear_flags(2'b10);
    check("R9 flags cleared", {src_bus, src_loc}, 0);

    // R2 short dominant aborts, next long one fires
    zero(); bus_pulse(BUS_F - 3);
    check("R2 short dominant no wake", n_bus, 0);
    bus_pulse(BUS_F + 1);
    check("R2 rearmed wake", n_bus, 1);
    clear_flags(2'b10);

    // R3 already low at entry
    mode = 2'b00; step(2); bus_lvl = 0; step(2); mode = 2'b10; zero();
    step((BUS_F + 4) * TP); bus_lvl = 1; step(3 * TP);
    check("R3 no wake without falling edge", n_bus, 0);
    bus_pulse(BUS_F + 1);
    check("R3 wake after real edge", n_bus, 1);
    clear_flags(2'b10);

    // R4 silent mode txd gate
    mode = 2'b01; txd = 0; step(4); zero(); bus_pulse(BUS_F + 3);
    check("R4 silent txd low blocks", n_bus, 0);
    txd = 1; step(2); bus_pulse(BUS_F + 3);
    check("R4 silent txd high wakes", n_bus, 1);
    clear_flags(2'b10);

    // R5 local wake fires while pin still low
    zero(); wk_pin = 0; step((LOC_F + 2) * TP);
    check("R5 local wake before release", n_loc, 1);
    check("R8 src_loc set", src_loc, 1);

    // R6 short high does not re-arm; long high does
    wk_pin = 1; step(TP); wk_pin = 0; zero(); step((LOC_F + 3) * TP);
    check("R6 short high no rearm", n_loc, 0);
    wk_pin = 1; step((RE_F + 2) * TP); wk_pin = 0; step((LOC_F + 2) * TP);
    check("R6 rearm after long high", n_loc, 1);
    wk_pin = 1; step(2);

    // R8 first source retained
    bus_pulse(BUS_F + 1);
    check("R8 later bus wake keeps src_loc", {src_bus, src_loc}, 1);
    clear_flags(2'b10);

    // R8 tie: both sources qualify together
    zero(); bus_lvl = 0; step(3 * TP); wk_pin = 0;
    while (!(l_in_low && l_lo == LOC_F - 1 && tc == TP - 1)) step(1);
    bus_lvl = 1; step(4);
    wk_pin = 1; step(2);
    check("R8 tie bus event", n_bus, 1);
    check("R8 tie loc event", n_loc, 1);
    check("R8 tie bus priority", {src_bus, src_loc}, 2);

    check("R10 events one cycle wide", max_run, 1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule